// File: doc/BRIEF.md
# USB Endpoint Bank Status Tracker

This block holds the bank bookkeeping for one USB device endpoint that uses two or three packet buffers in rotation. It keeps a CPU-side bank pointer, the number of occupied banks, the 2-bit data-toggle value and a short-packet flag. From these it derives an endpoint interrupt. The packet buffers, the serial engine and the register bus sit outside the block. The block only tracks which banks are full and which PID comes next.

The serial engine reports host-side events: an ACK received for a sent IN packet, or an OUT data packet with its PID and byte count. The CPU side supplies a one-cycle release strobe for each bank it has finished with, plus an enable for the busy-bank interrupt. A release takes effect only after a fixed pipeline latency. This models the settling delay between the CPU's write and the updated pointer. The direction input selects the IN or OUT bookkeeping rules. The control input marks a control endpoint.

Top module: `usb_ep_bank_tracker`

## Requirements
- R1: After reset, `busy_cnt` is 0, `cur_bank` is 00, `data_tog` is 01 (encoding: 00 = DATA0, 01 = DATA1, 1x never produced) and `short_pkt` is 0.
- R2: On an IN endpoint, an effective CPU release adds one to `busy_cnt` and moves the bank pointer to the next bank, wrapping from NUM_BANKS-1 to 0. A release while `busy_cnt` equals NUM_BANKS changes neither value.
- R3: On an IN endpoint, `tx_ack` with `busy_cnt` above 0 removes one from `busy_cnt` and flips `data_tog` between 00 and 01. With `busy_cnt` at 0, it changes nothing. `data_tog` changes on no other event.
- R4: On an OUT endpoint, `rx_valid` is accepted when `rx_pid` (0 = DATA0, 1 = DATA1) differs from `data_tog[0]` and `busy_cnt` is below NUM_BANKS. An accepted packet adds one to `busy_cnt` and sets `data_tog` to {0, `rx_pid`}. `rx_accept` shows acceptance in the same cycle.
- R5: On an OUT endpoint, a packet with the repeated PID, or one arriving with every bank busy, leaves `busy_cnt`, `data_tog` and `short_pkt` unchanged.
- R6: On an OUT endpoint, an effective CPU release removes one from `busy_cnt`, advances the bank pointer and clears `short_pkt`. With `busy_cnt` at 0, it changes nothing.
- R7: A `cpu_release` sampled at clock edge E affects the state first after edge E+RELEASE_LAT. Before that, the state is unchanged.
- R8: `ep_irq` is high exactly when `busy_irq_en` is 1 and either the endpoint is IN with `busy_cnt` = 0, or it is OUT with `busy_cnt` = NUM_BANKS.
- R9: An accepted OUT packet with `rx_len` below MAX_PKT on a non-control endpoint sets `short_pkt`. If a release clears it in the same cycle, the set wins.
- R10: With `cfg_ctrl` = 1, `cur_bank` reads 00 and `short_pkt` is never set.
- R11: A release taking effect in the same cycle as a host event applies both changes, so `busy_cnt` moves by their net.
- R12: With NUM_BANKS = 3, the bank pointer reaches 10 and `busy_cnt` reaches 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint (static) |
| cfg_ctrl | input | 1 | 1 = control endpoint (static) |
| busy_irq_en | input | 1 | Busy-bank interrupt enable |
| cpu_release | input | 1 | One-cycle strobe: CPU releases the current bank |
| tx_ack | input | 1 | Host ACKed the last IN packet |
| rx_valid | input | 1 | OUT data packet received without error |
| rx_pid | input | 1 | PID of received packet, 0 = DATA0, 1 = DATA1 |
| rx_len | input | LEN_W | Byte count of received packet |
| cur_bank | output | 2 | CPU-side bank index |
| busy_cnt | output | 2 | Number of occupied banks |
| data_tog | output | 2 | IN: next PID to send; OUT: last PID accepted |
| short_pkt | output | 1 | Short OUT packet received |
| ep_irq | output | 1 | Endpoint busy-bank interrupt |
| rx_accept | output | 1 | Current OUT packet is stored into a bank |

## Verification
The IN bookkeeping is tried with these patterns:
- Releases up to and past full, which separates saturation from wrap.
- ACKs down to and past empty, which shows that the toggle flips only on a real pop.

The OUT bookkeeping is tried with these patterns:
- Alternating PIDs, which tells apart a fresh packet from a repeated one.
- A correct-PID packet arriving with every bank busy.
- Short and full-length packets.

Directed patterns then place a release exactly RELEASE_LAT edges before a host packet to expose net counting. They count edges after a release to pin the latency. They run a three-bank copy to reach bank index 10, and a control endpoint to show the masked bank and short flag.

// File: rtl/ep_bank_pkg.sv
`timescale 1ns/1ps
package ep_bank_pkg;

    localparam logic [1:0] TOG_DATA0 = 2'b00;
    localparam logic [1:0] TOG_DATA1 = 2'b01;

    typedef struct packed {
        logic [1:0] bank;
        logic [1:0] busy;
        logic [1:0] tog;
        logic       shrt;
    } ep_state_t;

    function automatic logic [1:0] bank_step(input logic [1:0] cur, input logic [1:0] last);
        return (cur == last) ? 2'b00 : cur + 2'b01;
    endfunction

endpackage

// File: rtl/ep_release_pipe.sv
`timescale 1ns/1ps
module ep_release_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic fire_o
);
    logic [LAT-1:0] sr_q;
    logic [LAT-1:0] sr_d;

    generate
        if (LAT == 1) begin : g_one
            always_comb sr_d = strobe_i;
        end else begin : g_many
            always_comb sr_d = {sr_q[LAT-2:0], strobe_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign fire_o = sr_q[LAT-1];
endmodule

// File: rtl/ep_host_eval.sv
`timescale 1ns/1ps
module ep_host_eval #(
    parameter int NUM_BANKS = 2,
    parameter int MAX_PKT   = 64,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input  logic             dir_in,
    input  logic             ctrl,
    input  logic [1:0]       busy,
    input  logic             tog_lsb,
    input  logic             tx_ack,
    input  logic             rx_valid,
    input  logic             rx_pid,
    input  logic [LEN_W-1:0] rx_len,
    output logic             out_take,
    output logic             in_pop,
    output logic             short_hit
);
    localparam logic [1:0]       FULL = NUM_BANKS[1:0];
    localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_PKT);

    always_comb begin
        out_take  = rx_valid && !dir_in && (busy < FULL) && (rx_pid != tog_lsb);
        in_pop    = tx_ack && dir_in && (busy != 2'b00);
        short_hit = out_take && !ctrl && (rx_len < MAXL);
    end
endmodule

// File: rtl/ep_irq_gen.sv
`timescale 1ns/1ps
module ep_irq_gen #(
    parameter int NUM_BANKS = 2
) (
    input  logic       dir_in,
    input  logic       enable,
    input  logic [1:0] busy,
    output logic       irq_o
);
    localparam logic [1:0] FULL = NUM_BANKS[1:0];

    always_comb begin
        if (dir_in) irq_o = enable && (busy == 2'b00);
        else        irq_o = enable && (busy == FULL);
    end
endmodule

// File: rtl/usb_ep_bank_tracker.sv
`timescale 1ns/1ps
module usb_ep_bank_tracker
    import ep_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int MAX_PKT     = 64,
    parameter int RELEASE_LAT = 2,
    localparam int LEN_W      = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dir_in,
    input  logic             cfg_ctrl,
    input  logic             busy_irq_en,
    input  logic             cpu_release,
    input  logic             tx_ack,
    input  logic             rx_valid,
    input  logic             rx_pid,
    input  logic [LEN_W-1:0] rx_len,
    output logic [1:0]       cur_bank,
    output logic [1:0]       busy_cnt,
    output logic [1:0]       data_tog,
    output logic             short_pkt,
    output logic             ep_irq,
    output logic             rx_accept
);
    localparam logic [1:0] FULL = NUM_BANKS[1:0];
    localparam logic [1:0] LAST = FULL - 2'b01;

    ep_state_t st_q, st_d;
    logic rel_fire, out_take, in_pop, short_hit;
    logic push, pop, adv;

    ep_release_pipe #(.LAT(RELEASE_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cpu_release),
        .fire_o   (rel_fire)
    );

    ep_host_eval #(.NUM_BANKS(NUM_BANKS), .MAX_PKT(MAX_PKT)) u_host (
        .dir_in    (cfg_dir_in),
        .ctrl      (cfg_ctrl),
        .busy      (st_q.busy),
        .tog_lsb   (st_q.tog[0]),
        .tx_ack    (tx_ack),
        .rx_valid  (rx_valid),
        .rx_pid    (rx_pid),
        .rx_len    (rx_len),
        .out_take  (out_take),
        .in_pop    (in_pop),
        .short_hit (short_hit)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_dir_in) begin
            push = rel_fire && (st_q.busy < FULL);
            pop  = in_pop;
            adv  = push;
        end else begin
            push = out_take;
            pop  = rel_fire && (st_q.busy != 2'b00);
            adv  = pop;
        end
        st_d.busy = st_q.busy + {1'b0, push} - {1'b0, pop};
        if (adv) st_d.bank = bank_step(st_q.bank, LAST);
        if (cfg_dir_in && in_pop) st_d.tog = {1'b0, ~st_q.tog[0]};
        if (out_take)             st_d.tog = {1'b0, rx_pid};
        if (short_hit)                st_d.shrt = 1'b1;
        else if (!cfg_dir_in && pop)  st_d.shrt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bank <= 2'b00;
            st_q.busy <= 2'b00;
            st_q.tog  <= TOG_DATA1;
            st_q.shrt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ep_irq_gen #(.NUM_BANKS(NUM_BANKS)) u_irq (
        .dir_in (cfg_dir_in),
        .enable (busy_irq_en),
        .busy   (st_q.busy),
        .irq_o  (ep_irq)
    );

    assign cur_bank  = cfg_ctrl ? 2'b00 : st_q.bank;
    assign busy_cnt  = st_q.busy;
    assign data_tog  = st_q.tog;
    assign short_pkt = st_q.shrt;
    assign rx_accept = out_take;
endmodule

// File: rtl/usb_ep_bank_tracker_chk.sv
`timescale 1ns/1ps
module usb_ep_bank_tracker_chk #(
    parameter int NUM_BANKS = 2,
    parameter int MAX_PKT   = 64,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_dir_in,
    input logic             cfg_ctrl,
    input logic             tx_ack,
    input logic             rx_valid,
    input logic             rx_pid,
    input logic [LEN_W-1:0] rx_len,
    input logic [1:0]       busy_cnt,
    input logic [1:0]       data_tog,
    input logic             short_pkt
);
    localparam logic [1:0]       FULL = NUM_BANKS[1:0];
    localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_PKT);

    // R2, R12: occupancy never exceeds the bank count
    a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= FULL);

    // R1: reserved toggle codes never appear
    a_r1_tog_legal: assert property (@(posedge clk) disable iff (!rst_n)
        data_tog[1] == 1'b0);

    // R3: IN toggle moves only on an ACK
    a_r3_in_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && !tx_ack) |=> $stable(data_tog));

    // R5: repeated PID leaves the toggle alone
    a_r5_dup_pid: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && rx_valid && (rx_pid == data_tog[0])) |=> $stable(data_tog));

    // R9: accepted short packet sets the flag
    a_r9_short_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && !cfg_ctrl && rx_valid && (rx_pid != data_tog[0])
         && (busy_cnt < FULL) && (rx_len < MAXL)) |=> short_pkt);

    // R10: control endpoint never raises the short flag
    a_r10_ctrl_short: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl |=> !$rose(short_pkt));

    // R11: occupancy moves by at most one per cycle
    a_r11_busy_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (busy_cnt == $past(busy_cnt)) || (busy_cnt == $past(busy_cnt) + 2'b01)
                 || (busy_cnt + 2'b01 == $past(busy_cnt)));
endmodule

bind usb_ep_bank_tracker usb_ep_bank_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_PKT   (MAX_PKT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dir_in (cfg_dir_in),
    .cfg_ctrl   (cfg_ctrl),
    .tx_ack     (tx_ack),
    .rx_valid   (rx_valid),
    .rx_pid     (rx_pid),
    .rx_len     (rx_len),
    .busy_cnt   (busy_cnt),
    .data_tog   (data_tog),
    .short_pkt  (short_pkt)
);

// File: tb/usb_ep_bank_tracker_test.sv
`timescale 1ns/1ps
module usb_ep_bank_tracker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dir_in = 1'b1, cfg_ctrl = 1'b0, busy_irq_en = 1'b1;
    logic cpu_release = 1'b0, tx_ack = 1'b0, rx_valid = 1'b0, rx_pid = 1'b0;
    logic [6:0] rx_len = 7'd0;
    logic [1:0] cur_bank, busy_cnt, data_tog, cur_bank3, busy3, tog3;
    logic short_pkt, ep_irq, rx_accept, short3, irq3, acc3;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    usb_ep_bank_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_ctrl(cfg_ctrl),
        .busy_irq_en(busy_irq_en), .cpu_release(cpu_release), .tx_ack(tx_ack),
        .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_len(rx_len),
        .cur_bank(cur_bank), .busy_cnt(busy_cnt), .data_tog(data_tog),
        .short_pkt(short_pkt), .ep_irq(ep_irq), .rx_accept(rx_accept));

    usb_ep_bank_tracker #(.NUM_BANKS(3)) uut3 (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_ctrl(cfg_ctrl),
        .busy_irq_en(busy_irq_en), .cpu_release(cpu_release), .tx_ack(tx_ack),
        .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_len(rx_len),
        .cur_bank(cur_bank3), .busy_cnt(busy3), .data_tog(tog3),
        .short_pkt(short3), .ep_irq(irq3), .rx_accept(acc3));

    // [12] dir_in, [11:10] op (1 release, 2 ack, 3 rx), [9] pid, [8] short len,
    // expected: [7:6] busy, [5:4] toggle, [3:2] bank, [1] short, [0] irq
    localparam logic [12:0] VEC [13] = '{
        13'b1_01_0_0_01_01_01_0_0,   // R2 release
        13'b1_01_0_0_10_01_00_0_0,   // R2 wrap
        13'b1_01_0_0_10_01_00_0_0,   // R2 release when full ignored
        13'b1_10_0_0_01_00_00_0_0,   // R3 ack flips toggle
        13'b1_10_0_0_00_01_00_0_1,   // R3 R8 empty, irq
        13'b1_10_0_0_00_01_00_0_1,   // R3 ack when empty ignored
        13'b0_11_0_0_01_00_00_0_0,   // R4 DATA0 accepted
        13'b0_11_0_0_01_00_00_0_0,   // R5 repeated DATA0 dropped
        13'b0_11_1_1_10_01_00_1_1,   // R4 R9 R8 short DATA1, full
        13'b0_11_0_0_10_01_00_1_1,   // R5 no free bank
        13'b0_01_0_0_01_01_01_0_0,   // R6 release clears short
        13'b0_01_0_0_00_01_00_0_0,   // R6
        13'b0_01_0_0_00_01_00_0_0    // R6 release when empty ignored
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic dir, input logic ctrl);
        @(negedge clk);
        rst_n = 1'b0; cfg_dir_in = dir; cfg_ctrl = ctrl;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic step(input logic rel, input logic ack, input logic rxv,
                        input logic pid, input logic [6:0] len);
        @(negedge clk);
        cpu_release = rel; tx_ack = ack; rx_valid = rxv; rx_pid = pid; rx_len = len;
        @(posedge clk); #1;
        cpu_release = 1'b0; tx_ack = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 7'd0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(1'b1, 1'b0);
        chk("R1 busy", busy_cnt, 0);
        chk("R1 bank", cur_bank, 0);
        chk("R1 tog", data_tog, 1);
        chk("R1 short", short_pkt, 0);
        chk("R8 irq IN empty", ep_irq, 1);

        for (int v = 0; v < 13; v++) begin
            logic [12:0] e;
            e = VEC[v];
            if (e[12] != cfg_dir_in) do_reset(e[12], 1'b0);
            case (e[11:10])
                2'd1: step(1, 0, 0, 0, 7'd0);
                2'd2: step(0, 1, 0, 0, 7'd0);
                default: step(0, 0, 1, e[9], e[8] ? 7'd10 : 7'd64);
            endcase
            idle(3);
            chk("R2-R6 table busy", busy_cnt, int'(e[7:6]));
            chk("R3 R4 table tog", data_tog, int'(e[5:4]));
            chk("R2 R6 table bank", cur_bank, int'(e[3:2]));
            chk("R9 table short", short_pkt, int'(e[1]));
            chk("R8 table irq", ep_irq, int'(e[0]));
        end

        // R7 latency
        do_reset(1'b1, 1'b0);
        step(1, 0, 0, 0, 7'd0);
        chk("R7 edge E", busy_cnt, 0);
        idle(1);
        chk("R7 edge E+1", busy_cnt, 0);
        idle(1);
        chk("R7 edge E+2", busy_cnt, 1);

        // R8 enable off
        do_reset(1'b1, 1'b0);
        busy_irq_en = 1'b0;
        #1;
        chk("R8 irq disabled", ep_irq, 0);
        busy_irq_en = 1'b1;

        // R12 three banks
        do_reset(1'b1, 1'b0);
        step(1, 0, 0, 0, 7'd0); idle(2);
        step(1, 0, 0, 0, 7'd0); idle(2);
        chk("R12 bank 2", cur_bank3, 2);
        step(1, 0, 0, 0, 7'd0); idle(2);
        chk("R12 wrap", cur_bank3, 0);
        chk("R12 busy 3", busy3, 3);
        chk("R2 two-bank saturates", busy_cnt, 2);

        // R10 control endpoint
        do_reset(1'b0, 1'b1);
        step(0, 0, 1, 0, 7'd5); idle(1);
        chk("R10 short masked", short_pkt, 0);
        chk("R4 ctrl accepted", busy_cnt, 1);
        step(1, 0, 0, 0, 7'd0); idle(3);
        chk("R10 bank masked", cur_bank, 0);
        chk("R6 ctrl released", busy_cnt, 0);

        // R11 release effect and accept in the same cycle; R5 reject strobe
        do_reset(1'b0, 1'b0);
        step(0, 0, 1, 0, 7'd64);
        @(negedge clk);
        rx_valid = 1'b1; rx_pid = 1'b0; #1;
        chk("R5 rx_accept low on repeat", rx_accept, 0);
        rx_valid = 1'b0;
        step(1, 0, 0, 0, 7'd0);
        idle(1);
        step(0, 0, 1, 1, 7'd64);
        chk("R11 net busy", busy_cnt, 1);
        chk("R11 tog", data_tog, 1);
        idle(3);
        chk("R11 settled", busy_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule